// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the two error counters of a CAN controller node, one for transmit and one for receive, and from them derives the node's bus state: error active, error passive or bus off. The protocol engine drives it with single-cycle strobes. These strobes report transmit and receive errors, successful transmissions and receptions, and ACK errors seen while transmitting. A separate strobe marks each sampled bus bit and carries that bit's value. The block returns both counter values, a two-bit state code and a one-cycle interrupt pulse on entry to bus off.

When the node is in bus off, the receive and transmit event strobes have no effect. The only input that matters is the bit strobe. An internal run counter counts consecutive recessive bits. Each completed run of eleven advances the transmit counter by one. After 128 such runs the node returns to error active with both counters cleared.

The receive counter stops rising once it passes 127. The next good reception reloads it to 119, which lets a node whose transmit count is low fall back to error active.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, or while rst_n is low, both counters read 0, state_o reads 00 and busoff_irq_o is low.
- R2: Outside bus off, a tx_err_i strobe adds 8 to tx_cnt_o and a tx_ok_i strobe subtracts 1, with no change at 0. When both arrive in the same cycle, the error wins. Each new value appears after the next rising clock edge.
- R3: Outside bus off, an rx_err_i strobe adds 1 to rx_cnt_o and an rx_ok_i strobe subtracts 1, with no change at 0. When both arrive in the same cycle, the error wins.
- R4: When either counter becomes 128 or more, state_o becomes 01 (error passive).
- R5: From error passive, state_o returns to 00 once both counters are at 127 or below.
- R6: When rx_cnt_o is 128, further rx_err_i strobes leave it at 128.
- R7: An rx_ok_i strobe while rx_cnt_o is above 127 loads rx_cnt_o with 119.
- R8: A transmit increment that would take tx_cnt_o above 255 sets state_o to 10 (bus off) and clears tx_cnt_o. It also raises busoff_irq_o for exactly one cycle. rx_cnt_o is kept.
- R9: An ack_err_i strobe adds 8 to tx_cnt_o in error active. In error passive it leaves tx_cnt_o unchanged.
- R10: In bus off, the tx_err_i, rx_err_i, tx_ok_i, rx_ok_i and ack_err_i strobes leave both counters and the state unchanged.
- R11: In bus off, every 11 consecutive bit_vld_i strobes with bit_val_i = 1 (recessive) add 1 to tx_cnt_o. A strobe with bit_val_i = 0 (dominant) restarts the run and leaves tx_cnt_o unchanged. Cycles without bit_vld_i do not affect the run.
- R12: When tx_cnt_o would reach 128 in bus off, state_o becomes 00 and both counters become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_err_i | input | 1 | Transmit error strobe |
| rx_err_i | input | 1 | Receive error strobe |
| tx_ok_i | input | 1 | Successful transmission strobe |
| rx_ok_i | input | 1 | Successful reception strobe |
| ack_err_i | input | 1 | ACK error while transmitting strobe |
| bit_vld_i | input | 1 | Sampled bus bit strobe |
| bit_val_i | input | 1 | Sampled bit value, 1 = recessive |
| tx_cnt_o | output | CNT_W (8) | Transmit error counter |
| rx_cnt_o | output | CNT_W (8) | Receive error counter |
| state_o | output | 2 | 00 error active, 01 error passive, 1x bus off |
| busoff_irq_o | output | 1 | One-cycle pulse on entry to bus off |

## Verification
Each counter, the state code and the interrupt pulse pass through exactly one register. Every result of a strobe is therefore due on the first rising edge after the cycle in which the strobe is held. The bench changes its inputs only on falling edges and holds each strobe for one full cycle. It reads the outputs at the following falling edge, which is half a cycle after the edge that updates them. The interrupt is read at that same point and again one cycle later, to show that the pulse lasts exactly one cycle. Recovery results are checked after the last bit strobe of each run.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'b00,
        FC_PASSIVE = 2'b01,
        FC_BUSOFF  = 2'b10
    } fc_state_e;

endpackage

// File: rtl/fc_rx_counter.sv
module fc_rx_counter #(
    parameter int CNT_W  = 8,
    parameter int LIMIT  = 128,
    parameter int RELOAD = 119
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_i,
    input  logic             ok_i,
    input  logic             freeze_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic [CNT_W-1:0] cnt_q_o
);

    localparam logic [CNT_W-1:0] LIMIT_V  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(RELOAD);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (!freeze_i) begin
            if (err_i) begin
                if (cnt_q < LIMIT_V) cnt_d = cnt_q + 1'b1;
            end else if (ok_i) begin
                if (cnt_q >= LIMIT_V)  cnt_d = RELOAD_V;
                else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_d_o = cnt_d;
    assign cnt_q_o = cnt_q;

    // R6: saturation keeps the count at the limit
    a_r6_rx_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT_V);

    // R10: frozen counter holds unless a recovery clear arrives
    a_r10_rx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !clear_i) |=> $stable(cnt_q));

    // R7: a good reception above the limit lands on the reload value
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze_i && !clear_i && !err_i && ok_i && cnt_q >= LIMIT_V) |=> (cnt_q == RELOAD_V));

endmodule

// File: rtl/fc_run_counter.sv
module fc_run_counter #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic bit_vld_i,
    input  logic bit_rec_i,
    output logic wrap_o
);

    localparam int RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [RUN_W-1:0] LAST_V = RUN_W'(RUN_LEN - 1);

    logic [RUN_W-1:0] run_d, run_q;
    logic             wrap;

    always_comb begin
        run_d = run_q;
        wrap  = 1'b0;
        if (!en_i) begin
            run_d = '0;
        end else if (bit_vld_i) begin
            if (!bit_rec_i) begin
                run_d = '0;
            end else if (run_q == LAST_V) begin
                run_d = '0;
                wrap  = 1'b1;
            end else begin
                run_d = run_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign wrap_o = wrap;

    // R11: the run never exceeds its length
    a_r11_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(run_q) < RUN_LEN);

    // R11: a dominant bit restarts the run
    a_r11_dominant_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && bit_vld_i && !bit_rec_i) |=> (run_q == '0));

    // R11: cycles without a bit strobe leave the run alone
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !bit_vld_i) |=> $stable(run_q));

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
    import can_fc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int TX_ERR_INC  = 8,
    parameter int PASSIVE_LIM = 128,
    parameter int RX_RELOAD   = 119,
    parameter int RUN_LEN     = 11,
    parameter int RECOVER_CNT = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err_i,
    input  logic             rx_err_i,
    input  logic             tx_ok_i,
    input  logic             rx_ok_i,
    input  logic             ack_err_i,
    input  logic             bit_vld_i,
    input  logic             bit_val_i,
    output logic [CNT_W-1:0] tx_cnt_o,
    output logic [CNT_W-1:0] rx_cnt_o,
    output logic [1:0]       state_o,
    output logic             busoff_irq_o
);

    localparam logic [CNT_W-1:0] PASSIVE_V = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(RECOVER_CNT - 1);
    localparam logic [CNT_W:0]   TX_INC_V  = (CNT_W+1)'(TX_ERR_INC);

    typedef struct packed {
        logic [CNT_W-1:0] tx;
        fc_state_e        st;
        logic             irq;
    } fc_regs_t;

    fc_regs_t         r_d, r_q;
    logic             busoff;
    logic             run_wrap;
    logic             recover_done;
    logic             tx_hit;
    logic [CNT_W:0]   tx_sum;
    logic [CNT_W-1:0] rx_next, rx_cnt;

    assign busoff       = (r_q.st == FC_BUSOFF);
    assign recover_done = busoff && run_wrap && (r_q.tx == REC_LAST);

    fc_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (busoff),
        .bit_vld_i (bit_vld_i),
        .bit_rec_i (bit_val_i),
        .wrap_o    (run_wrap)
    );

    fc_rx_counter #(
        .CNT_W  (CNT_W),
        .LIMIT  (PASSIVE_LIM),
        .RELOAD (RX_RELOAD)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_i    (rx_err_i),
        .ok_i     (rx_ok_i),
        .freeze_i (busoff),
        .clear_i  (recover_done),
        .cnt_d_o  (rx_next),
        .cnt_q_o  (rx_cnt)
    );

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        tx_hit  = tx_err_i || (ack_err_i && r_q.st == FC_ACTIVE);
        tx_sum  = {1'b0, r_q.tx} + TX_INC_V;
        if (!busoff) begin
            if (tx_hit) begin
                if (tx_sum[CNT_W]) begin
                    r_d.tx  = '0;
                    r_d.st  = FC_BUSOFF;
                    r_d.irq = 1'b1;
                end else begin
                    r_d.tx = tx_sum[CNT_W-1:0];
                end
            end else if (tx_ok_i && r_q.tx != '0) begin
                r_d.tx = r_q.tx - 1'b1;
            end
            if (r_d.st != FC_BUSOFF) begin
                r_d.st = (r_d.tx >= PASSIVE_V || rx_next >= PASSIVE_V) ? FC_PASSIVE : FC_ACTIVE;
            end
        end else if (run_wrap) begin
            if (recover_done) begin
                r_d.tx = '0;
                r_d.st = FC_ACTIVE;
            end else begin
                r_d.tx = r_q.tx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{tx: '0, st: FC_ACTIVE, irq: 1'b0};
        else        r_q <= r_d;
    end

    assign tx_cnt_o     = r_q.tx;
    assign rx_cnt_o     = rx_cnt;
    assign state_o      = r_q.st;
    assign busoff_irq_o = r_q.irq;

    // R8: the interrupt lasts a single cycle
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_irq_o |=> !busoff_irq_o);

    // R8: entry into bus off comes with a cleared counter and the pulse
    a_r8_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (busoff && $past(r_q.st) != FC_BUSOFF) |-> (tx_cnt_o == '0 && busoff_irq_o));

    // R4 and R5: outside bus off, passive exactly when a counter is at the limit
    a_r4_passive_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busoff |-> ((r_q.st == FC_PASSIVE) == (tx_cnt_o >= PASSIVE_V || rx_cnt_o >= PASSIVE_V)));

    // R9: an ACK error in error passive leaves the transmit counter alone
    a_r9_ack_passive: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == FC_PASSIVE && ack_err_i && !tx_err_i && !tx_ok_i) |=> $stable(tx_cnt_o));

    // R10: in bus off only a completed recessive run moves the transmit counter
    a_r10_busoff_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busoff && !run_wrap) |=> ($stable(tx_cnt_o) && state_o == 2'b10));

    // R12: leaving bus off lands in error active with both counters cleared
    a_r12_recover: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.st) == FC_BUSOFF && !busoff) |-> (state_o == 2'b00 && tx_cnt_o == '0 && rx_cnt_o == '0));

endmodule

// File: tb/tb_can_fault_conf.sv
module tb_can_fault_conf;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0, ack_err = 0;
    logic       bit_vld = 0, bit_val = 0;
    logic [7:0] tx_cnt, rx_cnt;
    logic [1:0] state;
    logic       irq;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    can_fault_conf dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_err_i     (tx_err),
        .rx_err_i     (rx_err),
        .tx_ok_i      (tx_ok),
        .rx_ok_i      (rx_ok),
        .ack_err_i    (ack_err),
        .bit_vld_i    (bit_vld),
        .bit_val_i    (bit_val),
        .tx_cnt_o     (tx_cnt),
        .rx_cnt_o     (rx_cnt),
        .state_o      (state),
        .busoff_irq_o (irq)
    );

    typedef struct packed {
        logic       te, re, to, ro, ak;
        logic [7:0] etx;
        logic [7:0] erx;
        logic [1:0] est;
    } vec_t;

    // R2, R3, R9: basic counting in error active
    localparam vec_t VECS [10] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8,  8'd0, 2'b00},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd16, 8'd0, 2'b00},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd15, 8'd0, 2'b00},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd15, 8'd1, 2'b00},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd15, 8'd0, 2'b00},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd15, 8'd0, 2'b00},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd23, 8'd0, 2'b00},
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd23, 8'd1, 2'b00},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd31, 8'd1, 2'b00},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd30, 8'd1, 2'b00}
    };

    task automatic check(input string req, input int etx, input int erx, input int est);
        checks++;
        if (int'(tx_cnt) != etx || int'(rx_cnt) != erx || int'(state) != est) begin
            errors++;
            $display("FAIL %s: tx=%0d rx=%0d state=%0d, expected tx=%0d rx=%0d state=%0d",
                     req, tx_cnt, rx_cnt, state, etx, erx, est);
        end
    endtask

    task automatic check_irq(input string req, input logic exp);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s: irq=%0b, expected %0b", req, irq, exp);
        end
    endtask

    // called at a falling edge; holds the strobes for one cycle
    task automatic drive(input logic te, re, to, ro, ak, bv, bb);
        tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro; ack_err = ak;
        bit_vld = bv; bit_val = bb;
        @(negedge clk);
        tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; ack_err = 0;
        bit_vld = 0; bit_val = 0;
    endtask

    task automatic recessive(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 0, 0, 0);
        check_irq("R1 reset irq", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VECS[i]) begin
            drive(VECS[i].te, VECS[i].re, VECS[i].to, VECS[i].ro, VECS[i].ak, 0, 0);
            check($sformatf("R2/R3/R9 vector %0d", i), VECS[i].etx, VECS[i].erx, VECS[i].est);
        end

        // receive counter to passive, saturation, reload
        for (int i = 0; i < 126; i++) drive(0, 1, 0, 0, 0, 0, 0);
        check("R3 rx at 127", 30, 127, 0);
        drive(0, 1, 0, 0, 0, 0, 0);
        check("R4 rx passive", 30, 128, 1);
        drive(0, 1, 0, 0, 0, 0, 0);
        check("R6 rx saturated", 30, 128, 1);
        drive(0, 0, 0, 1, 0, 0, 0);
        check("R7 rx reload and R5 active", 30, 119, 0);

        // transmit counter to passive, ACK in passive, back to active
        for (int i = 0; i < 12; i++) drive(1, 0, 0, 0, 0, 0, 0);
        check("R2 tx at 126", 126, 119, 0);
        drive(1, 0, 0, 0, 0, 0, 0);
        check("R4 tx passive", 134, 119, 1);
        drive(0, 0, 0, 0, 1, 0, 0);
        check("R9 ack in passive", 134, 119, 1);
        for (int i = 0; i < 6; i++) drive(0, 0, 1, 0, 0, 0, 0);
        check("R5 still passive at 128", 128, 119, 1);
        drive(0, 0, 1, 0, 0, 0, 0);
        check("R5 tx back active", 127, 119, 0);

        // bus off entry
        for (int i = 0; i < 16; i++) drive(1, 0, 0, 0, 0, 0, 0);
        check("R8 tx at 255", 255, 119, 1);
        check_irq("R8 no irq before", 1'b0);
        drive(1, 0, 0, 0, 0, 0, 0);
        check("R8 bus off", 0, 119, 2);
        check_irq("R8 irq raised", 1'b1);
        @(negedge clk);
        check_irq("R8 irq single cycle", 1'b0);

        // strobes ignored in bus off
        drive(1, 0, 0, 0, 0, 0, 0);
        drive(0, 1, 0, 0, 0, 0, 0);
        drive(0, 0, 1, 0, 0, 0, 0);
        drive(0, 0, 0, 1, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 0, 0);
        check("R10 strobes ignored", 0, 119, 2);
        check_irq("R10 no irq", 1'b0);

        // recessive runs
        recessive(10);
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R11 dominant restarts run", 0, 119, 2);
        for (int i = 0; i < 20; i++) drive(0, 0, 0, 0, 0, 0, 1);
        check("R11 no strobe no count", 0, 119, 2);
        recessive(10);
        check("R11 ten recessive", 0, 119, 2);
        recessive(1);
        check("R11 eleventh recessive", 1, 119, 2);
        recessive(126 * 11);
        check("R11 127 runs", 127, 119, 2);
        recessive(10);
        check("R12 before last run", 127, 119, 2);
        recessive(1);
        check("R12 recovered", 0, 0, 0);

        // reset in the middle of activity
        drive(1, 1, 0, 0, 0, 0, 0);
        check("R2/R3 after recovery", 8, 1, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule